// File: doc/BRIEF.md
# Floppy Positioning Register Block

This block is the processor-facing side of a single-density floppy controller that serves four drives. It decodes a five-port I/O window with command/status, track, sector, data and extension ports. It keeps a private track, sector, status byte, step direction and interrupt flag for each drive, and it carries out the head-positioning commands within one clock cycle. It also builds the status byte and runs a per-drive head-unload timer.

Data-transfer commands (opcodes with bit 7 set) go to a separate transfer sequencer through a one-cycle hand-off pulse. Drive readiness and write protection come in as input signals. A host selects a drive through the extension port and then issues commands. It polls the extension port for completion.

Top module: `fdc_regblk`

## Requirements
- R1: After reset every drive has track 0, sector 1, status 0x00, inward step direction, no interrupt pending and an unloaded head. Drive 0 is selected, no hand-off pulse is driven, and an extension-port read returns 0x80.
- R2: Port offsets are 0 = status (read) and command (write), 1 = track, 2 = sector, 3 = data and 4 = extension. A written track, sector or data value reads back at the same offset, and read data appears one cycle after the read strobe. The data register is shared by all drives. Offsets 5 to 7 read 0xFF, and writes to them change nothing.
- R3: A write to port 4 selects drive number = bitwise inverse of data bits 5:4. Each drive keeps its own track and sector values.
- R4: Command 0x0X (restore) sets track 0. Command 0x1X (seek) loads the track from the data register when that value is below 77. Otherwise it sets status bit 4 (seek error) and leaves the track unchanged.
- R5: Command 0x4X/0x5X (step inward) sets the direction to +1, and command 0x6X/0x7X (step outward) sets it to -1. Command 0x2X/0x3X (step) moves in the stored direction. For all three, command bit 4 = 1 updates the track and bit 4 = 0 leaves it unchanged.
- R6: A step outward at track 0 and a step inward at track 76 each set the seek-error bit and leave the track unchanged.
- R7: A positioning command finishes at once and raises the drive's interrupt, so the extension port reads 0x00. Its status byte is built from these bits: 0x80 drive not ready, 0x40 write protected, 0x20 head loaded, 0x10 seek error, 0x04 track is 0, 0x02 index (always set). Busy (0x01) is clear.
- R8: Any command write clears the drive's interrupt. A command with bit 7 set, other than 0xDX, sets status to 0x01 (plus 0x80 if not ready). It drives `xfer_valid` high for exactly one cycle, one cycle after the write, with the command byte and drive number. A `xfer_done` pulse then clears busy and raises the selected drive's interrupt.
- R9: Command bit 3 on a positioning command loads the head. The head unloads once TIMEOUT_MS milliseconds pass with no port 0 to 3 access to that drive while it is selected. Each such access restarts the interval.
- R10: Command 0xDX (force interrupt) is also handed off. It clears busy and writes the positioning-style status bits while keeping the previous seek-error bit. It leaves the interrupt clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Port access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Port offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| drv_ready | input | DRIVES | Per-drive ready level |
| drv_wprot | input | DRIVES | Per-drive write-protect level |
| xfer_done | input | 1 | Transfer sequencer finished the command on the selected drive |
| xfer_valid | output | 1 | One-cycle hand-off strobe for a transfer command |
| xfer_cmd | output | 8 | Handed-off command byte |
| xfer_drive | output | clog2(DRIVES) | Drive the handed-off command targets |
| head_loaded | output | DRIVES | Per-drive head-loaded state |

## Verification
Most wrong internal state shows up at the ports within two port accesses. A corrupted track or direction register appears in the next track read, or in the track-zero and seek-error bits of the status written by the next positioning command. A wrong drive-select decode shows up as another drive's track or sector value on the very next read. A head-timer fault is visible on `head_loaded`, but only on the scale of the timeout. The bench therefore samples just inside and just beyond the interval, both after a load and after a restarting access.

// File: rtl/fdc_regs_pkg.sv
package fdc_regs_pkg;
  localparam logic [2:0] PORT_CMD = 3'd0;
  localparam logic [2:0] PORT_TRK = 3'd1;
  localparam logic [2:0] PORT_SEC = 3'd2;
  localparam logic [2:0] PORT_DAT = 3'd3;
  localparam logic [2:0] PORT_EXT = 3'd4;

  localparam logic [3:0] OPC_FORCE = 4'hD;

  localparam logic [7:0] EXT_IRQ_PENDING = 8'h00;
  localparam logic [7:0] EXT_IRQ_IDLE    = 8'h80;
  localparam logic [7:0] OPEN_BUS        = 8'hFF;
endpackage

// File: rtl/fdc_ms_tick.sv
module fdc_ms_tick #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int DIV = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int W   = $clog2(DIV + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == W'(DIV - 1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fdc_head_timer.sv
module fdc_head_timer #(
  parameter int TIMEOUT_MS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic load_i,
  input  logic touch_i,
  output logic loaded_o
);
  localparam int W = $clog2(TIMEOUT_MS + 1);

  logic [W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded_o <= 1'b0;
      age_q    <= '0;
    end else if (load_i) begin
      loaded_o <= 1'b1;
      age_q    <= '0;
    end else if (loaded_o && touch_i) begin
      age_q <= '0;
    end else if (loaded_o && tick_i) begin
      if (age_q == W'(TIMEOUT_MS - 1)) begin
        loaded_o <= 1'b0;
        age_q    <= '0;
      end else begin
        age_q <= age_q + 1'b1;
      end
    end
  end

  assert_load_sets_R9: assert property (@(posedge clk) disable iff (rst)
    load_i |=> loaded_o);
  assert_no_unload_between_ticks_R9: assert property (@(posedge clk) disable iff (rst)
    (loaded_o && !load_i && !touch_i && !tick_i) |=> loaded_o);
endmodule

// File: rtl/fdc_pos_calc.sv
module fdc_pos_calc #(
  parameter int TRACKS = 77
) (
  input  logic [3:0] opc_i,
  input  logic [7:0] trk_i,
  input  logic       dir_in_i,
  input  logic [7:0] seek_i,
  output logic [7:0] trk_o,
  output logic       dir_in_o,
  output logic       err_o
);
  localparam logic [7:0] LIMIT = 8'(TRACKS);
  localparam logic [7:0] LAST  = 8'(TRACKS - 1);

  logic step, go_in;

  always_comb begin
    trk_o    = trk_i;
    dir_in_o = dir_in_i;
    err_o    = 1'b0;
    step     = 1'b0;
    go_in    = dir_in_i;
    case (opc_i[3:1])
      3'b000: begin
        if (!opc_i[0])             trk_o = 8'd0;
        else if (seek_i < LIMIT)   trk_o = seek_i;
        else                       err_o = 1'b1;
      end
      3'b001: step = 1'b1;
      3'b010: begin step = 1'b1; go_in = 1'b1; dir_in_o = 1'b1; end
      3'b011: begin step = 1'b1; go_in = 1'b0; dir_in_o = 1'b0; end
      default: ;
    endcase
    if (step) begin
      if (go_in ? (trk_i >= LAST) : (trk_i == 8'd0)) err_o = 1'b1;
      else if (opc_i[0]) trk_o = go_in ? trk_i + 8'd1 : trk_i - 8'd1;
    end
  end
endmodule

// File: rtl/fdc_regblk.sv
module fdc_regblk
  import fdc_regs_pkg::*;
#(
  parameter int DRIVES     = 4,
  parameter int TRACKS     = 77,
  parameter int CLK_HZ     = 50_000_000,
  parameter int TIMEOUT_MS = 100
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [2:0]                 bus_addr,
  input  logic [7:0]                 bus_wdata,
  output logic [7:0]                 bus_rdata,
  input  logic [DRIVES-1:0]          drv_ready,
  input  logic [DRIVES-1:0]          drv_wprot,
  input  logic                       xfer_done,
  output logic                       xfer_valid,
  output logic [7:0]                 xfer_cmd,
  output logic [$clog2(DRIVES)-1:0]  xfer_drive,
  output logic [DRIVES-1:0]          head_loaded
);
  localparam int DSEL_W = $clog2(DRIVES);

  logic [DSEL_W-1:0] sel_q;
  logic [7:0]        data_q;
  logic              tick;

  logic [7:0] trk_a  [DRIVES];
  logic [7:0] sec_a  [DRIVES];
  logic [7:0] stat_a [DRIVES];
  logic       dir_a  [DRIVES];
  logic       irq_a  [DRIVES];

  wire wr_acc   = bus_sel &  bus_wr;
  wire rd_acc   = bus_sel & ~bus_wr;
  wire cmd_wr   = wr_acc && (bus_addr == PORT_CMD);
  wire is_pos   = ~bus_wdata[7];
  wire is_force = (bus_wdata[7:4] == OPC_FORCE);

  logic [7:0] pc_trk;
  logic       pc_dir, pc_err;
  wire  [7:0] cur_trk  = trk_a[sel_q];
  wire  [7:0] cur_stat = stat_a[sel_q];

  fdc_ms_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick));

  fdc_pos_calc #(.TRACKS(TRACKS)) u_pos (
    .opc_i(bus_wdata[7:4]), .trk_i(cur_trk), .dir_in_i(dir_a[sel_q]),
    .seek_i(data_q), .trk_o(pc_trk), .dir_in_o(pc_dir), .err_o(pc_err));

  for (genvar d = 0; d < DRIVES; d++) begin : g_drv
    localparam logic [DSEL_W-1:0] ID = DSEL_W'(d);
    wire hit   = (sel_q == ID);
    wire nrdy  = ~drv_ready[d];
    wire wp    = drv_wprot[d];
    wire load  = hit && cmd_wr && is_pos && bus_wdata[3];
    wire touch = hit && bus_sel && (bus_addr <= PORT_DAT);

    logic [7:0] trk_r, sec_r, stat_r;
    logic       dir_r, irq_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        trk_r <= 8'd0; sec_r <= 8'd1; stat_r <= 8'h00;
        dir_r <= 1'b1; irq_r <= 1'b0;
      end else if (hit) begin
        if (wr_acc && bus_addr == PORT_TRK) trk_r <= bus_wdata;
        if (wr_acc && bus_addr == PORT_SEC) sec_r <= bus_wdata;
        if (cmd_wr) begin
          irq_r <= 1'b0;
          if (is_pos) begin
            trk_r  <= pc_trk;
            dir_r  <= pc_dir;
            irq_r  <= 1'b1;
            stat_r <= {nrdy, wp, head_loaded[d] | bus_wdata[3], pc_err,
                       1'b0, pc_trk == 8'd0, 1'b1, 1'b0};
          end else if (is_force) begin
            stat_r <= {nrdy, wp, head_loaded[d], stat_r[4],
                       1'b0, trk_r == 8'd0, 1'b1, 1'b0};
          end else begin
            stat_r <= {nrdy, 7'b0000001};
          end
        end else if (xfer_done && stat_r[0]) begin
          stat_r[0] <= 1'b0;
          irq_r     <= 1'b1;
        end
      end
    end

    assign trk_a[d]  = trk_r;
    assign sec_a[d]  = sec_r;
    assign stat_a[d] = stat_r;
    assign dir_a[d]  = dir_r;
    assign irq_a[d]  = irq_r;

    fdc_head_timer #(.TIMEOUT_MS(TIMEOUT_MS)) u_head (
      .clk(clk), .rst(rst), .tick_i(tick), .load_i(load),
      .touch_i(touch), .loaded_o(head_loaded[d]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= '0;
      data_q     <= 8'h00;
      bus_rdata  <= 8'h00;
      xfer_valid <= 1'b0;
      xfer_cmd   <= 8'h00;
      xfer_drive <= '0;
    end else begin
      xfer_valid <= cmd_wr && !is_pos;
      if (cmd_wr && !is_pos) begin
        xfer_cmd   <= bus_wdata;
        xfer_drive <= sel_q;
      end
      if (wr_acc && bus_addr == PORT_DAT) data_q <= bus_wdata;
      if (wr_acc && bus_addr == PORT_EXT) sel_q <= ~bus_wdata[4 +: DSEL_W];
      if (rd_acc) begin
        case (bus_addr)
          PORT_CMD: bus_rdata <= cur_stat;
          PORT_TRK: bus_rdata <= cur_trk;
          PORT_SEC: bus_rdata <= sec_a[sel_q];
          PORT_DAT: bus_rdata <= data_q;
          PORT_EXT: bus_rdata <= irq_a[sel_q] ? EXT_IRQ_PENDING : EXT_IRQ_IDLE;
          default:  bus_rdata <= OPEN_BUS;
        endcase
      end
    end
  end

  assert_restore_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata[7:4] == 4'h0) |=> (cur_trk == 8'd0));
  assert_seek_range_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata[7:4] == 4'h1 && data_q >= 8'(TRACKS)) |=> ($stable(cur_trk) && cur_stat[4]));
  assert_outward_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata[7:5] == 3'b011 && cur_trk == 8'd0) |=> (cur_trk == 8'd0 && cur_stat[4]));
  assert_pos_done_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && is_pos) |=> (irq_a[sel_q] && !cur_stat[0] && cur_stat[1]));
  assert_handoff_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !is_pos && !is_force) |=> (xfer_valid && cur_stat[0] && !irq_a[sel_q]));
  assert_force_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && is_force) |=> (!cur_stat[0] && !irq_a[sel_q]));
endmodule

// File: tb/fdc_regblk_bench.sv
module fdc_regblk_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       bus_sel, bus_wr, xfer_done;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, xfer_cmd;
  logic [3:0] drv_ready, drv_wprot, head_loaded;
  logic       xfer_valid;
  logic [1:0] xfer_drive;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fdc_regblk #(.DRIVES(4), .TRACKS(77), .CLK_HZ(10_000), .TIMEOUT_MS(100)) u_fdc_regblk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .drv_ready(drv_ready),
    .drv_wprot(drv_wprot), .xfer_done(xfer_done), .xfer_valid(xfer_valid),
    .xfer_cmd(xfer_cmd), .xfer_drive(xfer_drive), .head_loaded(head_loaded));

  // {req, rd/addr nibble (8|addr = read, addr = write), data or expected}
  localparam int NV = 64;
  localparam logic [15:0] VEC [NV] = '{
    16'h1C80, 16'h1900, 16'h1A01, 16'h1800,                       // R1 reset state
    16'h2105, 16'h2905, 16'h221A, 16'h2A1A, 16'h2330, 16'h2B30,   // R2 readback
    16'h4010, 16'h4930, 16'h7802, 16'h7C00,                       // R4 seek, R7 status/irq
    16'h434D, 16'h4010, 16'h4930, 16'h4812,                       // R4 seek out of range
    16'h4000, 16'h4900, 16'h7806,                                 // R4 restore
    16'h5050, 16'h5901, 16'h5020, 16'h5901, 16'h5802, 16'h5030,   // R5 stepping
    16'h5902, 16'h5070, 16'h5901, 16'h5030, 16'h5900,
    16'h6030, 16'h6900, 16'h6816, 16'h6060, 16'h6816, 16'h614C,   // R6 limits
    16'h6050, 16'h694C, 16'h6812,
    16'h3420, 16'h3900, 16'h3A01, 16'h3122, 16'h3922,             // R3 drive select
    16'h7000, 16'h7846,                                           // R7 write protect
    16'h3430, 16'h394C, 16'h2B4D,                                 // R3 kept, R2 shared data
    16'h3400, 16'h7000, 16'h7886,                                 // R7 not ready
    16'h808F, 16'h8881, 16'h8C80,                                 // R8 transfer
    16'hA0D0, 16'hA886, 16'hAC80,                                 // R10 force interrupt
    16'h2577, 16'h2DFF, 16'h2900, 16'h2A01                        // R2 open ports
  };

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic run_all();
    logic [7:0] got;
    logic [15:0] v;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 head unloaded", {4'h0, head_loaded}, 8'h00);
    chk("R1 no handoff", {7'h0, xfer_valid}, 8'h00);
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      if (v[11]) begin
        rd(v[10:8], got);
        chk($sformatf("R%0d vector %0d", v[15:12], i), got, v[7:0]);
      end else begin
        wr(v[10:8], v[7:0]);
      end
    end
    // R8 hand-off timing on drive 3
    wr(3'd0, 8'hA4);
    chk("R8 valid", {7'h0, xfer_valid}, 8'h01);
    chk("R8 cmd", xfer_cmd, 8'hA4);
    chk("R8 drive", {6'h0, xfer_drive}, 8'h03);
    @(negedge clk);
    chk("R8 single pulse", {7'h0, xfer_valid}, 8'h00);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    rd(3'd0, got); chk("R8 done status", got, 8'h80);
    rd(3'd4, got); chk("R8 done irq", got, 8'h00);
    // R9 head load and timeout on drive 0
    wr(3'd4, 8'h30);
    wr(3'd0, 8'h08);
    chk("R9 loaded", {4'h0, head_loaded}, 8'h01);
    rd(3'd0, got); chk("R9 status head bit", got, 8'h26);
    repeat (500) @(negedge clk);
    chk("R9 held", {4'h0, head_loaded}, 8'h01);
    repeat (700) @(negedge clk);
    chk("R9 unloaded", {4'h0, head_loaded}, 8'h00);
    wr(3'd0, 8'h08);
    repeat (800) @(negedge clk);
    rd(3'd1, got);
    repeat (800) @(negedge clk);
    chk("R9 access restarts", {4'h0, head_loaded}, 8'h01);
    repeat (400) @(negedge clk);
    chk("R9 unload after access", {4'h0, head_loaded}, 8'h00);
    wr(3'd0, 8'h00);
    rd(3'd0, got); chk("R9 status after unload", got, 8'h06);
    // R1 reset mid-run
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h11);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(3'd4, got); chk("R1 ext after reset", got, 8'h80);
    rd(3'd1, got); chk("R1 drive0 track", got, 8'h00);
    rd(3'd2, got); chk("R1 drive0 sector", got, 8'h01);
    wr(3'd4, 8'h00);
    rd(3'd1, got); chk("R1 drive3 track", got, 8'h00);
  endtask

  initial begin
    rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 8'h00;
    xfer_done = 1'b0; drv_ready = 4'b0111; drv_wprot = 4'b0010;
    fork
      run_all();
      begin
        repeat (150_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule